// File: doc/BRIEF.md
# Configurable Two-Table Logic Cell

This block models one programmable logic cell of the kind that is tiled across a reconfigurable array. Two 3-input truth tables, a "carry" table and a "sum" table, each hold eight configuration bits. They read the same three-bit index. In logic mode a fourth data input picks which table drives the combinational output, so any function of four inputs can be built. In arithmetic mode the carry-in replaces the top index bit. The carry table then yields carry-out and the sum table yields the sum, which gives one full-adder stage per cell.

A single storage flop captures the combinational result. Its capture edge, the polarity of its clock enable, the polarity of its set/reset and the value that set/reset forces are all chosen by configuration. A final control bit routes either the stored or the combinational value to the cell's main output. The 22 configuration bits are loaded through a two-wire serial port with a shift enable and a data bit. Until a full image has arrived, every output is held at 0.

Top module: `lcell_top`

## Requirements
- R1: After reset, and until 22 configuration bits have been shifted in, `lut_out`, `q_out`, `cell_out` and `cout` are all 0, whatever the data, carry, enable and set/reset inputs are.
- R2: Each rising clock edge with `cfg_en` high shifts `cfg_din` into the configuration image, most significant bit first. After 22 shifts the first bit sent sits in bit 21. The image layout from bit 21 down to bit 0 is: output-select, arithmetic-mode, set/reset value, set/reset active-low, enable active-low, falling-edge (bits 21..16), then sum table entries 7..0 (bits 15..8), then carry table entries 7..0 (bits 7..0).
- R3: In logic mode (arithmetic-mode bit 0), with index i = `din[2:0]`, `lut_out` is sum table entry i when `din[3]` is 1 and carry table entry i when `din[3]` is 0. `cin` is ignored.
- R4: `cout` is always carry table entry i. In logic mode i is `din[2:0]`. In arithmetic mode i is {`cin`, `din[1:0]`}.
- R5: In arithmetic mode (arithmetic-mode bit 1), `lut_out` is sum table entry {`cin`, `din[1:0]`}. `din[3:2]` are ignored.
- R6: `cell_out` equals `q_out` when the output-select bit is 1, and equals `lut_out` when it is 0.
- R7: The flop captures `lut_out` on the rising clock edge when the falling-edge bit is 0, and on the falling edge when that bit is 1. It does not change on the other edge.
- R8: The clock enable is active high when the enable active-low bit is 0, and active low when that bit is 1. When the enable is inactive, the flop holds its value.
- R9: Set/reset is active high when its active-low bit is 0, and active low when that bit is 1. It acts only on the selected edge. While it is active, the flop loads the set/reset value bit, and this takes priority over the clock enable and the data.
- R10: A synchronous active-high `rst` clears the configuration image and the load count. After reset the outputs return to 0 until a fresh 22-bit image has been shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration port and the flop |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the configuration port |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| din | input | 4 | Data inputs; [2:0] index the tables, [3] picks the table in logic mode |
| cin | input | 1 | Carry in; top index bit in arithmetic mode |
| ce | input | 1 | Flop clock enable, polarity by configuration |
| sr | input | 1 | Flop synchronous set/reset, polarity by configuration |
| lut_out | output | 1 | Combinational cell result |
| q_out | output | 1 | Flop output |
| cell_out | output | 1 | Main output: stored or combinational value |
| cout | output | 1 | Carry table output |

## Verification
The combinational path is swept over all 16 data inputs with two different table pairs: odd/even parity, and a three-input AND/OR pair. Each table entry therefore shows up on both polarities, and a swapped table or a misplaced index bit gives a wrong value. Arithmetic mode is swept over all 32 combinations of carry-in and data using parity and majority tables. The unused upper data bits are toggled during this sweep, which separates a correct carry-in substitution from a plain 4-input selection. The flop is exercised with the enable held and released, with set/reset against opposing data, and with both polarity settings and both edge settings. A loaded-all-ones image that is one bit short shows the inert-until-loaded rule, and the final bit then releases it.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int LUT_IN = 3;
    localparam int TAB_W  = 1 << LUT_IN;
    localparam int DIN_W  = LUT_IN + 1;

    typedef struct packed {
        logic out_reg;   // 1: main output shows the stored value
        logic arith;     // 1: carry in replaces the top index bit
        logic sr_val;    // value loaded while set/reset is active
        logic sr_low;    // 1: set/reset active low
        logic ce_low;    // 1: clock enable active low
        logic fall;      // 1: capture on falling edge
    } cell_ctl_t;

    typedef struct packed {
        cell_ctl_t        ctl;
        logic [TAB_W-1:0] s_tab;
        logic [TAB_W-1:0] c_tab;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    typedef struct packed {
        logic lut;
        logic carry;
    } lut_res_t;

    function automatic logic tab_pick(input logic [TAB_W-1:0] tab,
                                      input logic [LUT_IN-1:0] idx);
        return tab[idx];
    endfunction

    function automatic logic level_on(input logic pin, input logic low);
        return pin ^ low;
    endfunction

endpackage

// File: rtl/lcell_cfg_shift.sv
module lcell_cfg_shift #(
    parameter int W = lcell_pkg::CFG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         shift_din,
    output logic [W-1:0] image,
    output logic         loaded
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            image <= '0;
            cnt   <= '0;
        end else if (shift_en) begin
            image <= {image[W-2:0], shift_din};
            if (cnt != CW'(W)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign loaded = (cnt == CW'(W));

endmodule

// File: rtl/lcell_lut_pair.sv
module lcell_lut_pair
    import lcell_pkg::*;
(
    input  cell_cfg_t        cfg,
    input  logic [DIN_W-1:0] din,
    input  logic             cin,
    output lut_res_t         res
);
    logic [LUT_IN-1:0] idx;
    logic              c_bit;
    logic              s_bit;

    always_comb begin
        idx = din[LUT_IN-1:0];
        if (cfg.ctl.arith) begin
            idx[LUT_IN-1] = cin;
        end
        c_bit     = tab_pick(cfg.c_tab, idx);
        s_bit     = tab_pick(cfg.s_tab, idx);
        res.carry = c_bit;
        res.lut   = (cfg.ctl.arith || din[LUT_IN]) ? s_bit : c_bit;
    end

endmodule

// File: rtl/lcell_ff.sv
module lcell_ff
    import lcell_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  cell_ctl_t ctl,
    input  logic      d,
    input  logic      ce,
    input  logic      sr,
    output logic      q
);
    logic q_rise;
    logic q_fall;
    logic sr_on;
    logic ce_on;

    assign sr_on = level_on(sr, ctl.sr_low);
    assign ce_on = level_on(ce, ctl.ce_low);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_rise <= 1'b0;
        end else if (enable && !ctl.fall) begin
            if (sr_on) begin
                q_rise <= ctl.sr_val;
            end else if (ce_on) begin
                q_rise <= d;
            end
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            q_fall <= 1'b0;
        end else if (enable && ctl.fall) begin
            if (sr_on) begin
                q_fall <= ctl.sr_val;
            end else if (ce_on) begin
                q_fall <= d;
            end
        end
    end

    assign q = ctl.fall ? q_fall : q_rise;

endmodule

// File: rtl/lcell_top.sv
module lcell_top
    import lcell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [DIN_W-1:0] din,
    input  logic             cin,
    input  logic             ce,
    input  logic             sr,
    output logic             lut_out,
    output logic             q_out,
    output logic             cell_out,
    output logic             cout
);
    logic [CFG_W-1:0] image;
    logic             loaded;
    cell_cfg_t        cfg;
    lut_res_t         res;
    logic             q_raw;

    lcell_cfg_shift #(.W(CFG_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (cfg_en),
        .shift_din (cfg_din),
        .image     (image),
        .loaded    (loaded)
    );

    assign cfg = cell_cfg_t'(image);

    lcell_lut_pair u_luts (
        .cfg (cfg),
        .din (din),
        .cin (cin),
        .res (res)
    );

    lcell_ff u_ff (
        .clk    (clk),
        .rst    (rst),
        .enable (loaded),
        .ctl    (cfg.ctl),
        .d      (res.lut),
        .ce     (ce),
        .sr     (sr),
        .q      (q_raw)
    );

    assign lut_out  = loaded & res.lut;
    assign cout     = loaded & res.carry;
    assign q_out    = loaded & q_raw;
    assign cell_out = cfg.ctl.out_reg ? q_out : lut_out;

endmodule

// File: rtl/lcell_checker.sv
module lcell_checker
    import lcell_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_en,
    input logic             loaded,
    input cell_cfg_t        cfg,
    input logic [DIN_W-1:0] din,
    input logic             ce,
    input logic             sr,
    input logic             lut_out,
    input logic             q_out,
    input logic             cell_out,
    input logic             cout
);
    logic sr_act;
    logic ce_act;
    assign sr_act = sr ^ cfg.ctl.sr_low;
    assign ce_act = ce ^ cfg.ctl.ce_low;

    AST_INERT_UNLOADED: assert property (@(posedge clk) disable iff (rst)
        !loaded |-> (lut_out == 1'b0 && q_out == 1'b0 && cell_out == 1'b0 && cout == 1'b0)); // R1

    AST_LOAD_STICKS: assert property (@(posedge clk) disable iff (rst)
        loaded |=> loaded); // R2

    AST_CARRY_LOGIC: assert property (@(posedge clk) disable iff (rst)
        (loaded && !cfg.ctl.arith) |-> cout == cfg.c_tab[din[LUT_IN-1:0]]); // R4

    AST_OUT_STORED: assert property (@(posedge clk) disable iff (rst)
        (loaded && cfg.ctl.out_reg) |-> cell_out == q_out); // R6

    AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (loaded && !cfg_en && !cfg.ctl.fall && !sr_act && ce_act) |=> q_out == $past(lut_out)); // R7

    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (loaded && !cfg_en && !cfg.ctl.fall && !sr_act && !ce_act) |=> $stable(q_out)); // R8

    AST_SR_WINS: assert property (@(posedge clk) disable iff (rst)
        (loaded && !cfg_en && !cfg.ctl.fall && sr_act) |=> q_out == $past(cfg.ctl.sr_val)); // R9

    AST_RESET_UNLOADS: assert property (@(posedge clk)
        rst |=> !loaded); // R10

endmodule

bind lcell_top lcell_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .loaded   (loaded),
    .cfg      (cfg),
    .din      (din),
    .ce       (ce),
    .sr       (sr),
    .lut_out  (lut_out),
    .q_out    (q_out),
    .cell_out (cell_out),
    .cout     (cout)
);

// File: tb/lcell_top_bench.sv
module lcell_top_bench;

    localparam int CLK_P  = 10;
    localparam int NBITS  = 22;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [3:0] din = '0;
    logic       cin = 1'b0;
    logic       ce = 1'b0;
    logic       sr = 1'b0;
    logic       lut_out, q_out, cell_out, cout;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    lcell_top u_lcell_top (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .din      (din),
        .cin      (cin),
        .ce       (ce),
        .sr       (sr),
        .lut_out  (lut_out),
        .q_out    (q_out),
        .cell_out (cell_out),
        .cout     (cout)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NBITS-1:0] mk(input logic [5:0] ctl, input logic [7:0] s, input logic [7:0] c);
        return {ctl, s, c};
    endfunction

    function automatic logic [2:0] ix_of(input logic [NBITS-1:0] k, input logic [3:0] d, input logic c);
        return k[20] ? {c, d[1:0]} : d[2:0];
    endfunction

    function automatic logic exp_lut(input logic [NBITS-1:0] k, input logic [3:0] d, input logic c);
        logic [2:0] ix;
        ix = ix_of(k, d, c);
        if (k[20] || d[3]) return k[8 + ix];
        return k[ix];
    endfunction

    function automatic logic exp_cout(input logic [NBITS-1:0] k, input logic [3:0] d, input logic c);
        return k[ix_of(k, d, c)];
    endfunction

    task automatic do_reset();
        rst = 1'b1; cfg_en = 1'b0; din = '0; cin = 1'b0; ce = 1'b0; sr = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic shift_bits(input logic [NBITS-1:0] k, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            cfg_en = 1'b1; cfg_din = k[i];
            @(posedge clk); #1;
        end
        cfg_en = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        din = 4'hF; cin = 1'b1; ce = 1'b1; sr = 1'b1;
        @(posedge clk); #1;
        check("R1 lut_out after reset", lut_out, 1'b0);
        check("R1 q_out after reset", q_out, 1'b0);
        check("R10 cell_out after reset", cell_out, 1'b0);
        check("R1 cout after reset", cout, 1'b0);
    endtask

    task automatic t_partial_load();
        logic [NBITS-1:0] k;
        k = mk(6'b000000, 8'hFF, 8'hFF);
        do_reset();
        shift_bits(k, NBITS-1, 1);
        din = 4'h5;
        #1;
        check("R1 lut_out with 21 bits", lut_out, 1'b0);
        check("R1 cout with 21 bits", cout, 1'b0);
        shift_bits(k, 0, 0);
        check("R2 lut_out after bit 22", lut_out, 1'b1);
        check("R2 cout after bit 22", cout, 1'b1);
    endtask

    task automatic t_logic(input logic [7:0] s, input logic [7:0] c);
        logic [NBITS-1:0] k;
        k = mk(6'b000000, s, c);
        do_reset();
        shift_bits(k, NBITS-1, 0);
        for (int v = 0; v < 16; v++) begin
            din = 4'(v); cin = ~din[0];
            #1;
            check("R3 logic lut_out", lut_out, exp_lut(k, din, cin));
            check("R4 logic cout", cout, exp_cout(k, din, cin));
            check("R6 comb cell_out", cell_out, exp_lut(k, din, cin));
        end
    endtask

    task automatic t_arith();
        logic [NBITS-1:0] k;
        k = mk(6'b010000, 8'h96, 8'hE8);
        do_reset();
        shift_bits(k, NBITS-1, 0);
        for (int v = 0; v < 32; v++) begin
            din = v[3:0]; cin = v[4];
            #1;
            check("R5 sum", lut_out, din[0] ^ din[1] ^ cin);
            check("R4 carry", cout, (din[0] & din[1]) | (cin & (din[0] | din[1])));
        end
    endtask

    task automatic t_rise_flop();
        do_reset();
        shift_bits(mk(6'b100000, 8'hAA, 8'hAA), NBITS-1, 0);
        din = 4'h1; ce = 1'b1; sr = 1'b0;
        #1;
        check("R6 cell_out before edge", cell_out, 1'b0);
        @(posedge clk); #1;
        check("R7 rise capture", q_out, 1'b1);
        check("R6 cell_out shows q", cell_out, 1'b1);
        din = 4'h0; ce = 1'b0;
        @(posedge clk); #1;
        check("R8 hold with ce low", q_out, 1'b1);
        din = 4'h1; ce = 1'b1; sr = 1'b1;
        @(posedge clk); #1;
        check("R9 sr forces 0", q_out, 1'b0);
    endtask

    task automatic t_polarity();
        do_reset();
        shift_bits(mk(6'b101110, 8'hAA, 8'hAA), NBITS-1, 0);
        din = 4'h1; ce = 1'b0; sr = 1'b1;
        @(posedge clk); #1;
        check("R8 active-low ce loads", q_out, 1'b1);
        din = 4'h0; ce = 1'b1;
        @(posedge clk); #1;
        check("R8 active-low ce holds", q_out, 1'b1);
        ce = 1'b0; sr = 1'b0;
        @(posedge clk); #1;
        check("R9 active-low sr sets 1 over data", q_out, 1'b1);
        sr = 1'b1;
        @(posedge clk); #1;
        check("R8 data loads after sr release", q_out, 1'b0);
    endtask

    task automatic t_fall_flop();
        do_reset();
        shift_bits(mk(6'b100001, 8'hAA, 8'hAA), NBITS-1, 0);
        din = 4'h1; ce = 1'b1; sr = 1'b0;
        #2;
        check("R7 no change before falling edge", q_out, 1'b0);
        @(negedge clk); #1;
        check("R7 falling capture", q_out, 1'b1);
        din = 4'h0;
        @(posedge clk); #1;
        check("R7 rising edge ignored", q_out, 1'b1);
        @(negedge clk); #1;
        check("R7 falling capture 0", q_out, 1'b0);
    endtask

    task automatic t_mid_reset();
        do_reset();
        shift_bits(mk(6'b000000, 8'hFF, 8'hFF), NBITS-1, 0);
        din = 4'h7;
        #1;
        check("R3 loaded before reset", lut_out, 1'b1);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        check("R10 lut_out after reset", lut_out, 1'b0);
        @(posedge clk); #1;
        check("R10 stays inert", cout, 1'b0);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_partial_load();
        t_logic(8'h69, 8'h96);
        t_logic(8'hFE, 8'h80);
        t_arith();
        t_rise_flop();
        t_polarity();
        t_fall_flop();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule